// File: doc/BRIEF.md
# Receive Byte Buffer with Discard-on-Overrun

This block is the receive-side byte store for a 16550-style serial controller. Bytes arrive one per cycle on a push strobe from a line or console source and are kept in a small circular store. The host side sees the oldest stored byte on a combinational data output and consumes it by pulsing a read strobe. That strobe corresponds to a read of the receive buffer register. Two status bits, data-ready and overrun-error, are produced here for the line status register.

Read and write positions are free-running counters, and only their low bits index the store. The buffer counts as empty when the low bits of the two counters match, so at most DEPTH-1 bytes are ever held. A push that would make the low bits meet does not drop the newest byte. It throws away the whole contents: both counters return to zero and the overrun bit is raised. A separate flush input, driven by the receive-reset bit of the FIFO control register, clears both counters and both status bits. An overrun-clear pulse, issued by the register block when the host reads the line status, clears the overrun bit alone.

Top module: `rxbuf_top`

## Requirements
- R1: After reset, data_ready_o and overrun_o are 0 and rbr_data_o is 0x00.
- R2: While the buffer holds bytes, rbr_data_o shows the oldest one. Each read strobe consumes one byte, so bytes leave in the order they were pushed.
- R3: In the cycle after any push that is not flushed, data_ready_o is 1, including a push that causes an overrun.
- R4: A read that leaves the buffer empty clears data_ready_o. A read that leaves bytes behind keeps it at 1.
- R5: When the buffer is empty, rbr_data_o is 0x00. A read strobe then does not advance the read position, and a later push followed by a read returns the pushed byte.
- R6: A push while DEPTH-1 bytes are held and no read is strobed discards all contents. The buffer becomes empty, overrun_o becomes 1 and data_ready_o is 1. The next read returns 0x00 and clears data_ready_o.
- R7: A flush empties the buffer and clears data_ready_o and overrun_o. It takes precedence over a push or read in the same cycle.
- R8: An overrun-clear pulse clears overrun_o only. Stored bytes and data_ready_o are kept.
- R9: When a push and a read come in the same cycle, the read takes the old oldest byte first and the push is applied afterwards. With DEPTH-1 bytes held, this does not cause an overrun.
- R10: When an overrun and an overrun-clear pulse occur in the same cycle, overrun_o ends up 1.
- R11: Byte order stays correct across many wraps of the position counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid_i | input | 1 | Store push_byte_i this cycle |
| push_byte_i | input | 8 | Incoming byte |
| rbr_read_i | input | 1 | Host reads the receive buffer register this cycle |
| rbr_data_o | output | 8 | Oldest stored byte, 0x00 when empty |
| fcr_rx_flush_i | input | 1 | Receive flush from the FIFO control register write |
| lsr_oe_clr_i | input | 1 | Overrun-clear pulse from a line status read |
| data_ready_o | output | 1 | Data-ready status bit |
| overrun_o | output | 1 | Overrun-error status bit |

## Verification
The bench builds the buffer with DEPTH = 4 and an 8-bit data width. At that depth, three stored bytes fill the buffer, so the discard-on-overrun path is reached within a few pushes. The position counters are one bit wider than the index and therefore wrap every eight bytes. This lets a short stream of forty bytes cover many counter wraps and check the same-cycle push-and-read ordering at the full mark. The default depth of 16 is used only for elaboration.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
    localparam int RXB_DEPTH_DEF  = 16;
    localparam int RXB_DATA_W_DEF = 8;

    // Index width for a power-of-two depth of at least two.
    function automatic int rxb_idx_w(input int depth);
        return (depth < 2) ? 1 : $clog2(depth);
    endfunction
endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store #(
    parameter int DEPTH  = rxbuf_pkg::RXB_DEPTH_DEF,
    parameter int DATA_W = rxbuf_pkg::RXB_DATA_W_DEF,
    localparam int IW    = rxbuf_pkg::rxb_idx_w(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [IW-1:0]     wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [IW-1:0]     rd_idx_i,
    output logic [DATA_W-1:0] rd_data_o
);
    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            cells_q[wr_idx_i] <= wr_data_i;
        end
    end

    assign rd_data_o = cells_q[rd_idx_i];
endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl #(
    parameter int DEPTH = rxbuf_pkg::RXB_DEPTH_DEF,
    localparam int IW   = rxbuf_pkg::rxb_idx_w(DEPTH),
    localparam int CW   = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          rd_i,
    input  logic          flush_i,
    input  logic          oe_clr_i,
    output logic          wr_en_o,
    output logic [IW-1:0] wr_idx_o,
    output logic [IW-1:0] rd_idx_o,
    output logic          empty_o,
    output logic          dr_o,
    output logic          oe_o
);
    typedef struct packed {
        logic [CW-1:0] wr;
        logic [CW-1:0] rd;
        logic          dr;
        logic          oe;
    } ctl_t;

    localparam logic [IW-1:0] FULL_FILL = IW'(DEPTH - 1);

    ctl_t state_d, state_q;
    logic empty_q;
    logic [IW-1:0] fill_q;

    assign empty_q = (state_q.wr[IW-1:0] == state_q.rd[IW-1:0]);
    assign fill_q  = state_q.wr[IW-1:0] - state_q.rd[IW-1:0];

    // Read is applied first, then push, then overrun-clear yields to a new
    // overrun, and a flush overrides everything.
    always_comb begin
        state_d = state_q;
        if (rd_i && !empty_q) begin
            state_d.rd = state_q.rd + 1'b1;
        end
        if (rd_i && (state_d.rd[IW-1:0] == state_q.wr[IW-1:0])) begin
            state_d.dr = 1'b0;
        end
        if (oe_clr_i) begin
            state_d.oe = 1'b0;
        end
        if (push_i) begin
            state_d.wr = state_q.wr + 1'b1;
            state_d.dr = 1'b1;
            if (state_d.wr[IW-1:0] == state_d.rd[IW-1:0]) begin
                state_d.wr = '0;
                state_d.rd = '0;
                state_d.oe = 1'b1;
            end
        end
        if (flush_i) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign wr_en_o  = push_i;
    assign wr_idx_o = state_q.wr[IW-1:0];
    assign rd_idx_o = state_q.rd[IW-1:0];
    assign empty_o  = empty_q;
    assign dr_o     = state_q.dr;
    assign oe_o     = state_q.oe;

    assert_push_sets_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !flush_i) |=> dr_o);

    assert_empty_read_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && empty_o && !push_i && !flush_i) |=> (empty_o && $stable(rd_idx_o)));

    assert_overrun_discards_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !rd_i && !flush_i && fill_q == FULL_FILL) |=> (oe_o && empty_o && dr_o));

    assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!dr_o && !oe_o && empty_o));

    assert_oe_clear_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_clr_i && !push_i && !rd_i && !flush_i) |=> (!oe_o && dr_o == $past(dr_o)));

    assert_full_push_read_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && rd_i && !flush_i && fill_q == FULL_FILL) |=> (fill_q == FULL_FILL));
endmodule

// File: rtl/rxbuf_top.sv
module rxbuf_top #(
    parameter int DEPTH  = rxbuf_pkg::RXB_DEPTH_DEF,
    parameter int DATA_W = rxbuf_pkg::RXB_DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid_i,
    input  logic [DATA_W-1:0] push_byte_i,
    input  logic              rbr_read_i,
    output logic [DATA_W-1:0] rbr_data_o,
    input  logic              fcr_rx_flush_i,
    input  logic              lsr_oe_clr_i,
    output logic              data_ready_o,
    output logic              overrun_o
);
    localparam int IW = rxbuf_pkg::rxb_idx_w(DEPTH);

    logic              wr_en;
    logic [IW-1:0]     wr_idx;
    logic [IW-1:0]     rd_idx;
    logic              empty;
    logic [DATA_W-1:0] head;

    rxbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push_valid_i),
        .rd_i     (rbr_read_i),
        .flush_i  (fcr_rx_flush_i),
        .oe_clr_i (lsr_oe_clr_i),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx),
        .rd_idx_o (rd_idx),
        .empty_o  (empty),
        .dr_o     (data_ready_o),
        .oe_o     (overrun_o)
    );

    rxbuf_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (push_byte_i),
        .rd_idx_i  (rd_idx),
        .rd_data_o (head)
    );

    // R5: an empty buffer presents zero rather than stale storage.
    assign rbr_data_o = empty ? '0 : head;
endmodule

// File: tb/tb_rxbuf_top.sv
module tb_rxbuf_top;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push = 1'b0;
    logic [7:0] pbyte = 8'h00;
    logic       rd = 1'b0;
    logic [7:0] rdata;
    logic       flush = 1'b0;
    logic       oclr = 1'b0;
    logic       dr;
    logic       oe;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    rxbuf_top #(.DEPTH(DEPTH), .DATA_W(8)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .push_valid_i   (push),
        .push_byte_i    (pbyte),
        .rbr_read_i     (rd),
        .rbr_data_o     (rdata),
        .fcr_rx_flush_i (flush),
        .lsr_oe_clr_i   (oclr),
        .data_ready_o   (dr),
        .overrun_o      (oe)
    );

    typedef struct packed {
        logic       push;
        logic [7:0] pbyte;
        logic       rd;
        logic       flush;
        logic       oclr;
        logic [7:0] exp_data;
        logic       exp_dr;
        logic       exp_oe;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'd3},  // R3 first push
        '{1'b1, 8'hB2, 1'b0, 1'b0, 1'b0, 8'hA1, 1'b1, 1'b0, 4'd2},  // R2 head shown
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hA1, 1'b1, 1'b0, 4'd4},  // R4 bytes remain
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'hB2, 1'b0, 1'b0, 4'd4},  // R4 last byte read
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 empty read
        '{1'b1, 8'hC3, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'd5},  // R5 push after
        '{1'b1, 8'hD4, 1'b1, 1'b0, 1'b0, 8'hC3, 1'b1, 1'b0, 4'd9},  // R9 read then push
        '{1'b1, 8'hE5, 1'b0, 1'b0, 1'b0, 8'hD4, 1'b1, 1'b0, 4'd2},
        '{1'b1, 8'hF6, 1'b0, 1'b0, 1'b0, 8'hD4, 1'b1, 1'b0, 4'd2},  // now full
        '{1'b1, 8'h77, 1'b1, 1'b0, 1'b0, 8'hD4, 1'b1, 1'b0, 4'd9},  // R9 no overrun
        '{1'b1, 8'h88, 1'b0, 1'b0, 1'b0, 8'hE5, 1'b1, 1'b1, 4'd6},  // R6 overrun
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 4'd8},  // R8 clear oe only
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'd6},  // R6 read zero
        '{1'b1, 8'h99, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'd3},
        '{1'b1, 8'hAA, 1'b0, 1'b0, 1'b0, 8'h99, 1'b1, 1'b0, 4'd2},
        '{1'b1, 8'hBB, 1'b0, 1'b0, 1'b0, 8'h99, 1'b1, 1'b0, 4'd2},
        '{1'b1, 8'hCC, 1'b0, 1'b0, 1'b1, 8'h99, 1'b1, 1'b1, 4'd10}, // R10 set wins
        '{1'b1, 8'h11, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'd7},  // R7 flush wins
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'd7},  // R7 push dropped
        '{1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 4'd3},
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 8'h22, 1'b0, 1'b0, 4'd2}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic p, input logic [7:0] b, input logic r,
                         input logic f, input logic c);
        push = p; pbyte = b; rd = r; flush = f; oclr = c;
    endtask

    task automatic idle();
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle();
        repeat (3) @(negedge clk);
        check("R1", "reset data_ready", int'(dr), 0);
        check("R1", "reset overrun", int'(oe), 0);
        check("R1", "reset rbr_data", int'(rdata), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            @(negedge clk);
            drive(VECS[i].push, VECS[i].pbyte, VECS[i].rd, VECS[i].flush, VECS[i].oclr);
            #1;
            check(tag, $sformatf("vec %0d rbr_data", i), int'(rdata), int'(VECS[i].exp_data));
            @(posedge clk);
            #1;
            check(tag, $sformatf("vec %0d data_ready", i), int'(dr), int'(VECS[i].exp_dr));
            check(tag, $sformatf("vec %0d overrun", i), int'(oe), int'(VECS[i].exp_oe));
        end
        @(negedge clk);
        idle();

        // R8: overrun cleared while a byte is stored keeps the byte and ready
        do_reset();
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            drive(1'b1, 8'h40 + 8'(i), 1'b0, 1'b0, 1'b0);
        end
        @(negedge clk);
        drive(1'b1, 8'h5A, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        idle();
        #1;
        check("R8", "overrun after clear", int'(oe), 0);
        check("R8", "ready kept", int'(dr), 1);
        check("R8", "byte kept", int'(rdata), 'h5A);

        // R11: stream across many counter wraps with one byte in flight
        do_reset();
        @(negedge clk);
        drive(1'b1, 8'd3, 1'b0, 1'b0, 1'b0);
        for (int i = 1; i < 40; i++) begin
            @(negedge clk);
            drive(1'b1, 8'(i * 7 + 3), 1'b1, 1'b0, 1'b0);
            #1;
            check("R11", $sformatf("wrap byte %0d", i), int'(rdata), (((i - 1) * 7) + 3) & 'hFF);
        end
        @(negedge clk);
        drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0);
        #1;
        check("R11", "last wrap byte", int'(rdata), ((39 * 7) + 3) & 'hFF);
        @(posedge clk);
        #1;
        check("R4", "ready cleared after stream", int'(dr), 0);
        check("R6", "no overrun in stream", int'(oe), 0);

        // R1: reset in the middle of activity
        @(negedge clk);
        drive(1'b1, 8'h66, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        idle();
        do_reset();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule